// File: doc/BRIEF.md
# Multi-mode lookup-table slice

This block is a logic slice built around two small lookup tables, called table A and table B. Each table holds 2^AW one-bit cells; the default is AW = 4, giving 16 cells. A three-bit mode input decides what the storage does. It can act as a pair of combinational function generators. It can act as a synchronous-write RAM, either as two independent 16 x 1 memories or joined into a 16 x 2 memory, a 32 x 1 memory or a 16 x 1 dual-port memory. It can also act as a pair of addressable 16-stage shift registers.

Each table drives a combinational output, and that output also feeds a flip-flop with its own clock enable and synchronous reset. A whole-table load port fills either table in one clock, in any mode. This is how the contents of a function generator are set.

Top module: `lut_slice`

## Requirements
- R1: Mode encoding: 0 = logic, 1 = two independent 16x1 RAMs, 2 = 16x2 RAM, 3 = 32x1 RAM, 4 = dual-port RAM, 5 = shift; values 6 and 7 behave as logic. In logic mode comb_a is bit addr_a of table A and comb_b is bit addr_b of table B, so any function of four inputs is realised by the loaded pattern.
- R2: On a clock edge with cfg_load high, the table picked by cfg_sel (0 = A, 1 = B) takes cfg_data whole, bit i going to cell i; this happens in every mode and overrides any write or shift to that table in the same cycle.
- R3: In logic mode, wr_en, din_a and din_b have no effect on either table.
- R4: In mode 1, wr_en writes din_a into table A at addr_a and din_b into table B at addr_b on the same edge.
- R5: In mode 2, both tables use addr_a for writing and reading: din_a goes to A and din_b goes to B, comb_a reads A and comb_b reads B at addr_a, and addr_b is ignored.
- R6: In mode 3, addr_hi is the fifth address bit: 0 writes din_a into A, 1 into B, at addr_a. comb_a reads the selected table at addr_a, and comb_b reads B at addr_a.
- R7: In mode 4, a write stores din_a at addr_a in both tables, din_b is ignored, comb_a reads at addr_a and comb_b reads at addr_b.
- R8: In mode 5, an edge with wr_en high shifts each table up by one cell and puts din_a (A) or din_b (B) into cell 0. The output shows cell addr, which is the bit shifted in addr+1 strobes ago.
- R9: RAM reads are asynchronous: while a write to the addressed cell is pending, the output shows the old value, and it shows the new value right after the edge.
- R10: reg_a and reg_b clear on an edge with ff_rst high, whatever ff_ce is. Otherwise they take comb_a and comb_b on an edge with ff_ce high, and hold when ff_ce is low.
- R11: In mode 5, an edge with wr_en low leaves both shift registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the tables and the output flip-flops |
| ff_rst | input | 1 | Synchronous reset of reg_a and reg_b |
| ff_ce | input | 1 | Clock enable of reg_a and reg_b |
| mode | input | 3 | Storage mode (encoding in R1) |
| cfg_load | input | 1 | Load a whole table from cfg_data |
| cfg_sel | input | 1 | Table to load: 0 = A, 1 = B |
| cfg_data | input | 2^AW | Table contents, bit i into cell i |
| addr_a | input | AW | Select/address input of table A |
| addr_b | input | AW | Select/address input of table B |
| addr_hi | input | 1 | Fifth address bit in 32x1 mode |
| wr_en | input | 1 | Write enable, or shift strobe in shift mode |
| din_a | input | 1 | Write or shift-in data for table A |
| din_b | input | 1 | Write or shift-in data for table B |
| comb_a | output | 1 | Combinational output of table A |
| comb_b | output | 1 | Combinational output of table B |
| reg_a | output | 1 | Registered copy of comb_a |
| reg_b | output | 1 | Registered copy of comb_b |

## Verification
The properties assume that the tables hold known data before ff_rst is released, and that no whole-table load lands in the cycles they observe. They also assume that the mode and the read addresses stay put across the edge they look at. The stimulus loads both tables while ff_rst is still high. After that it changes mode and addresses only between edges, and it raises cfg_load only in steps that expect a load to win.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
   localparam logic [2:0] SLICE_LOGIC    = 3'd0;
   localparam logic [2:0] SLICE_RAM_1X   = 3'd1;
   localparam logic [2:0] SLICE_RAM_WIDE = 3'd2;
   localparam logic [2:0] SLICE_RAM_DEEP = 3'd3;
   localparam logic [2:0] SLICE_RAM_DUAL = 3'd4;
   localparam logic [2:0] SLICE_SHIFT    = 3'd5;
   localparam int NUM_TABLES = 2;
endpackage

// File: rtl/lut_slice_cell.sv
module lut_slice_cell #(
   parameter int AW = 4,
   localparam int DEPTH = 1 << AW
) (
   input  logic             clk,
   input  logic             load,
   input  logic [DEPTH-1:0] load_data,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic             wdata,
   input  logic             shift,
   input  logic             sin,
   input  logic [AW-1:0]    raddr,
   output logic             rdata
);
   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk) begin
      if (load)
         cells <= load_data;
      else if (shift)
         cells <= {cells[DEPTH-2:0], sin};
      else if (we)
         cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/lut_slice_ctrl.sv
module lut_slice_ctrl
   import lut_slice_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic [2:0]                  mode,
   input  logic                        cfg_load,
   input  logic                        cfg_sel,
   input  logic [AW-1:0]               addr_a,
   input  logic [AW-1:0]               addr_b,
   input  logic                        addr_hi,
   input  logic                        wr_en,
   input  logic                        din_a,
   input  logic                        din_b,
   output logic [NUM_TABLES-1:0]       load,
   output logic [NUM_TABLES-1:0]       we,
   output logic [NUM_TABLES-1:0][AW-1:0] waddr,
   output logic [NUM_TABLES-1:0]       wdata,
   output logic [NUM_TABLES-1:0]       shift,
   output logic [NUM_TABLES-1:0]       sin,
   output logic [NUM_TABLES-1:0][AW-1:0] raddr,
   output logic                        out_a_from_b
);
   always_comb begin
      load         = {cfg_load & cfg_sel, cfg_load & ~cfg_sel};
      we           = '0;
      shift        = '0;
      sin          = {din_b, din_a};
      waddr        = {addr_a, addr_a};
      wdata        = {din_a, din_a};
      raddr        = {addr_b, addr_a};
      out_a_from_b = 1'b0;
      case (mode)
         SLICE_RAM_1X: begin
            we    = {wr_en, wr_en};
            waddr = {addr_b, addr_a};
            wdata = {din_b, din_a};
         end
         SLICE_RAM_WIDE: begin
            we    = {wr_en, wr_en};
            wdata = {din_b, din_a};
            raddr = {addr_a, addr_a};
         end
         SLICE_RAM_DEEP: begin
            we           = {wr_en & addr_hi, wr_en & ~addr_hi};
            raddr        = {addr_a, addr_a};
            out_a_from_b = addr_hi;
         end
         SLICE_RAM_DUAL: begin
            we = {wr_en, wr_en};
         end
         SLICE_SHIFT: begin
            shift = {wr_en, wr_en};
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/lut_slice_oreg.sv
module lut_slice_oreg (
   input  logic clk,
   input  logic srst,
   input  logic ce,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (srst)
         q <= 1'b0;
      else if (ce)
         q <= d;
   end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
   import lut_slice_pkg::*;
#(
   parameter int AW = 4,
   localparam int DEPTH = 1 << AW
) (
   input  logic             clk,
   input  logic             ff_rst,
   input  logic             ff_ce,
   input  logic [2:0]       mode,
   input  logic             cfg_load,
   input  logic             cfg_sel,
   input  logic [DEPTH-1:0] cfg_data,
   input  logic [AW-1:0]    addr_a,
   input  logic [AW-1:0]    addr_b,
   input  logic             addr_hi,
   input  logic             wr_en,
   input  logic             din_a,
   input  logic             din_b,
   output logic             comb_a,
   output logic             comb_b,
   output logic             reg_a,
   output logic             reg_b
);
   generate
      if (AW < 2 || AW > 6) begin : g_bad_aw
         $error("lut_slice: AW must lie between 2 and 6");
      end
   endgenerate

   logic [NUM_TABLES-1:0]         t_load, t_we, t_wdata, t_shift, t_sin, t_rd;
   logic [NUM_TABLES-1:0][AW-1:0] t_waddr, t_raddr;
   logic                          a_from_b;
   logic [NUM_TABLES-1:0]         comb_v, reg_v;

   lut_slice_ctrl #(.AW(AW)) u_ctrl (
      .mode(mode), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
      .addr_a(addr_a), .addr_b(addr_b), .addr_hi(addr_hi),
      .wr_en(wr_en), .din_a(din_a), .din_b(din_b),
      .load(t_load), .we(t_we), .waddr(t_waddr), .wdata(t_wdata),
      .shift(t_shift), .sin(t_sin), .raddr(t_raddr),
      .out_a_from_b(a_from_b)
   );

   assign comb_v[0] = a_from_b ? t_rd[1] : t_rd[0];
   assign comb_v[1] = t_rd[1];

   for (genvar g = 0; g < NUM_TABLES; g++) begin : g_tbl
      lut_slice_cell #(.AW(AW)) u_cell (
         .clk(clk), .load(t_load[g]), .load_data(cfg_data),
         .we(t_we[g]), .waddr(t_waddr[g]), .wdata(t_wdata[g]),
         .shift(t_shift[g]), .sin(t_sin[g]),
         .raddr(t_raddr[g]), .rdata(t_rd[g])
      );
      lut_slice_oreg u_oreg (
         .clk(clk), .srst(ff_rst), .ce(ff_ce), .d(comb_v[g]), .q(reg_v[g])
      );
   end

   assign comb_a = comb_v[0];
   assign comb_b = comb_v[1];
   assign reg_a  = reg_v[0];
   assign reg_b  = reg_v[1];
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
   import lut_slice_pkg::*;
#(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          ff_rst,
   input logic          ff_ce,
   input logic [2:0]    mode,
   input logic          cfg_load,
   input logic [AW-1:0] addr_a,
   input logic [AW-1:0] addr_b,
   input logic          addr_hi,
   input logic          wr_en,
   input logic          din_a,
   input logic          din_b,
   input logic          comb_a,
   input logic          comb_b,
   input logic          reg_a,
   input logic          reg_b
);
   a_r10_sync_clear: assert property (@(posedge clk)
      ff_rst |=> (reg_a == 1'b0 && reg_b == 1'b0));

   a_r10_capture: assert property (@(posedge clk) disable iff (ff_rst)
      ff_ce |=> (reg_a == $past(comb_a) && reg_b == $past(comb_b)));

   a_r10_hold: assert property (@(posedge clk) disable iff (ff_rst)
      !ff_ce |=> ($stable(reg_a) && $stable(reg_b)));

   a_r3_logic_ignores_write: assert property (@(posedge clk) disable iff (ff_rst)
      (mode == SLICE_LOGIC && !cfg_load) ##1
      (mode == SLICE_LOGIC && $stable(addr_a) && $stable(addr_b))
      |-> ($stable(comb_a) && $stable(comb_b)));

   a_r8_shift_in: assert property (@(posedge clk) disable iff (ff_rst)
      (mode == SLICE_SHIFT && wr_en && !cfg_load) ##1
      (mode == SLICE_SHIFT && addr_a == '0 && addr_b == '0)
      |-> (comb_a == $past(din_a) && comb_b == $past(din_b)));

   a_r11_shift_hold: assert property (@(posedge clk) disable iff (ff_rst)
      (mode == SLICE_SHIFT && !wr_en && !cfg_load) ##1
      (mode == SLICE_SHIFT && $stable(addr_a) && $stable(addr_b))
      |-> ($stable(comb_a) && $stable(comb_b)));

   a_r7_dual_mirror: assert property (@(posedge clk) disable iff (ff_rst)
      (mode == SLICE_RAM_DUAL && wr_en && !cfg_load) ##1
      (mode == SLICE_RAM_DUAL && addr_b == $past(addr_a))
      |-> (comb_b == $past(din_a)));

   a_r6_deep_select: assert property (@(posedge clk) disable iff (ff_rst)
      (mode == SLICE_RAM_DEEP && wr_en && !cfg_load) ##1
      (mode == SLICE_RAM_DEEP && $stable(addr_a) && $stable(addr_hi))
      |-> (comb_a == $past(din_a)));

   a_r5_wide_write: assert property (@(posedge clk) disable iff (ff_rst)
      (mode == SLICE_RAM_WIDE && wr_en && !cfg_load) ##1
      (mode == SLICE_RAM_WIDE && $stable(addr_a))
      |-> (comb_a == $past(din_a) && comb_b == $past(din_b)));
endmodule

bind lut_slice lut_slice_chk #(.AW(AW)) u_chk (
   .clk(clk), .ff_rst(ff_rst), .ff_ce(ff_ce), .mode(mode),
   .cfg_load(cfg_load), .addr_a(addr_a), .addr_b(addr_b),
   .addr_hi(addr_hi), .wr_en(wr_en), .din_a(din_a), .din_b(din_b),
   .comb_a(comb_a), .comb_b(comb_b), .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/sim_lut_slice.sv
module sim_lut_slice;
   logic        clk = 1'b0;
   logic        ff_rst, ff_ce, cfg_load, cfg_sel, addr_hi, wr_en, din_a, din_b;
   logic [2:0]  mode;
   logic [15:0] cfg_data;
   logic [3:0]  addr_a, addr_b;
   logic        comb_a, comb_b, reg_a, reg_b;

   logic [15:0] ma, mb;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   lut_slice #(.AW(4)) u0 (
      .clk(clk), .ff_rst(ff_rst), .ff_ce(ff_ce), .mode(mode),
      .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .addr_a(addr_a), .addr_b(addr_b), .addr_hi(addr_hi),
      .wr_en(wr_en), .din_a(din_a), .din_b(din_b),
      .comb_a(comb_a), .comb_b(comb_b), .reg_a(reg_a), .reg_b(reg_b)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R10 reset reg_a", reg_a, 1'b0);
      chk("R10 reset reg_b", reg_b, 1'b0);
      ff_rst = 1'b0;
   endtask

   task automatic t_logic();
      mode = 3'd0;
      for (int i = 0; i < 16; i++) begin
         addr_a = 4'(i); addr_b = 4'(15 - i);
         #1;
         chk("R1 logic comb_a", comb_a, ma[i]);
         chk("R1 logic comb_b", comb_b, mb[15 - i]);
      end
      mode = 3'd7; addr_a = 4'd2; addr_b = 4'd7;
      #1;
      chk("R1 mode 7 as logic a", comb_a, ma[2]);
      chk("R1 mode 7 as logic b", comb_b, mb[7]);
      mode = 3'd0;
   endtask

   task automatic t_logic_nowrite();
      mode = 3'd0; addr_a = 4'd5; addr_b = 4'd9;
      wr_en = 1'b1; din_a = ~ma[5]; din_b = ~mb[9];
      step();
      wr_en = 1'b0;
      #1;
      chk("R3 logic write ignored a", comb_a, ma[5]);
      chk("R3 logic write ignored b", comb_b, mb[9]);
   endtask

   task automatic t_ram1x();
      mode = 3'd1; addr_a = 4'd2; addr_b = 4'd7;
      din_a = ~ma[2]; din_b = ~mb[7]; wr_en = 1'b1;
      step();
      ma[2] = din_a; mb[7] = din_b; wr_en = 1'b0;
      #1;
      chk("R4 ram1x a written", comb_a, ma[2]);
      chk("R4 ram1x b written", comb_b, mb[7]);
      addr_a = 4'd3; addr_b = 4'd6;
      #1;
      chk("R4 ram1x a neighbour", comb_a, ma[3]);
      chk("R4 ram1x b neighbour", comb_b, mb[6]);
   endtask

   task automatic t_rdw();
      mode = 3'd1; addr_a = 4'd4; addr_b = 4'd4;
      din_a = ~ma[4]; din_b = mb[4]; wr_en = 1'b1;
      #1;
      chk("R9 old value before edge", comb_a, ma[4]);
      step();
      ma[4] = din_a; wr_en = 1'b0;
      chk("R9 new value after edge", comb_a, ma[4]);
   endtask

   task automatic t_load_prio();
      mode = 3'd1; cfg_load = 1'b1; cfg_sel = 1'b0; cfg_data = 16'h1234;
      wr_en = 1'b1; addr_a = 4'd0; addr_b = 4'd1; din_a = 1'b1; din_b = ~mb[1];
      step();
      ma = 16'h1234; mb[1] = din_b; cfg_load = 1'b0; wr_en = 1'b0;
      #1;
      chk("R2 load beats write", comb_a, 1'b0);
      chk("R4 other table still written", comb_b, mb[1]);
      addr_a = 4'd2;
      #1;
      chk("R2 loaded pattern", comb_a, 1'b1);
   endtask

   task automatic t_wide();
      mode = 3'd2; addr_a = 4'd10; addr_b = 4'd0;
      din_a = 1'b1; din_b = 1'b0; wr_en = 1'b1;
      step();
      ma[10] = 1'b1; mb[10] = 1'b0;
      addr_a = 4'd11; din_a = 1'b0; din_b = 1'b1;
      step();
      ma[11] = 1'b0; mb[11] = 1'b1; wr_en = 1'b0;
      addr_a = 4'd10; addr_b = 4'd11;
      #1;
      chk("R5 wide a", comb_a, 1'b1);
      chk("R5 wide b uses addr_a", comb_b, 1'b0);
      addr_a = 4'd11; addr_b = 4'd10;
      #1;
      chk("R5 wide a2", comb_a, 1'b0);
      chk("R5 wide b2", comb_b, 1'b1);
   endtask

   task automatic t_deep();
      mode = 3'd3; addr_a = 4'd3; addr_b = 4'd0; addr_hi = 1'b0;
      din_a = 1'b1; din_b = 1'b0; wr_en = 1'b1;
      step();
      ma[3] = 1'b1;
      addr_hi = 1'b1; din_a = 1'b0;
      step();
      mb[3] = 1'b0; wr_en = 1'b0;
      addr_hi = 1'b0;
      #1;
      chk("R6 deep lower half", comb_a, 1'b1);
      addr_hi = 1'b1;
      #1;
      chk("R6 deep upper half", comb_a, 1'b0);
      chk("R6 deep comb_b at addr_a", comb_b, mb[3]);
      addr_hi = 1'b0;
   endtask

   task automatic t_dual();
      mode = 3'd4; addr_a = 4'd6; addr_b = 4'd0;
      din_a = 1'b1; din_b = 1'b0; wr_en = 1'b1;
      step();
      ma[6] = 1'b1; mb[6] = 1'b1;
      addr_a = 4'd12; din_a = 1'b0; din_b = 1'b1;
      step();
      ma[12] = 1'b0; mb[12] = 1'b0; wr_en = 1'b0;
      addr_a = 4'd12; addr_b = 4'd6;
      #1;
      chk("R7 dual port a", comb_a, 1'b0);
      chk("R7 dual mirror b", comb_b, 1'b1);
      addr_a = 4'd6; addr_b = 4'd12;
      #1;
      chk("R7 dual port a2", comb_a, 1'b1);
      chk("R7 dual mirror ignores din_b", comb_b, 1'b0);
   endtask

   task automatic t_shift();
      logic [4:0] seq;
      seq = 5'b01101;
      mode = 3'd5; cfg_load = 1'b1; cfg_sel = 1'b0; cfg_data = 16'h8001;
      step();
      cfg_sel = 1'b1; cfg_data = 16'h0000;
      step();
      ma = 16'h8001; mb = 16'h0000; cfg_load = 1'b0;
      for (int k = 0; k < 5; k++) begin
         din_a = seq[k]; din_b = ~seq[k]; wr_en = 1'b1;
         step();
         ma = {ma[14:0], din_a}; mb = {mb[14:0], din_b};
      end
      wr_en = 1'b0;
      for (int t = 0; t < 6; t++) begin
         addr_a = 4'(t); addr_b = 4'(t);
         #1;
         chk("R8 shift tap a", comb_a, ma[t]);
         chk("R8 shift tap b", comb_b, mb[t]);
      end
      addr_a = 4'd15;
      #1;
      chk("R8 shift last stage", comb_a, ma[15]);
      addr_a = 4'd0; addr_b = 4'd1;
      step();
      step();
      chk("R11 no strobe hold a", comb_a, ma[0]);
      chk("R11 no strobe hold b", comb_b, mb[1]);
   endtask

   task automatic t_oreg();
      mode = 3'd0; cfg_load = 1'b1; cfg_sel = 1'b0; cfg_data = 16'h00FF;
      step();
      cfg_sel = 1'b1; cfg_data = 16'hFF00;
      step();
      ma = 16'h00FF; mb = 16'hFF00; cfg_load = 1'b0;
      addr_a = 4'd0; addr_b = 4'd0; ff_ce = 1'b1;
      step();
      chk("R10 capture a", reg_a, 1'b1);
      chk("R10 capture b", reg_b, 1'b0);
      ff_ce = 1'b0; addr_a = 4'd8; addr_b = 4'd8;
      step();
      chk("R10 hold a", reg_a, 1'b1);
      chk("R10 hold b", reg_b, 1'b0);
      ff_ce = 1'b1; ff_rst = 1'b1;
      step();
      chk("R10 reset beats enable a", reg_a, 1'b0);
      chk("R10 reset beats enable b", reg_b, 1'b0);
      ff_rst = 1'b0; addr_a = 4'd0; addr_b = 4'd8;
      step();
      chk("R10 capture after reset a", reg_a, 1'b1);
      chk("R10 capture after reset b", reg_b, 1'b1);
      ff_ce = 1'b0;
   endtask

   initial begin
      ff_rst = 1'b1; ff_ce = 1'b0; mode = 3'd0;
      cfg_load = 1'b1; cfg_sel = 1'b0; cfg_data = 16'hA5C3;
      addr_a = '0; addr_b = '0; addr_hi = 1'b0;
      wr_en = 1'b0; din_a = 1'b0; din_b = 1'b0;
      step();
      cfg_sel = 1'b1; cfg_data = 16'h6996;
      step();
      cfg_load = 1'b0; ma = 16'hA5C3; mb = 16'h6996;
      t_reset();
      t_logic();
      t_logic_nowrite();
      t_ram1x();
      t_rdw();
      t_load_prio();
      t_wide();
      t_deep();
      t_dual();
      t_shift();
      t_oreg();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule